// File: doc/BRIEF.md
# PECI Host Register Front-End

This block is the software-visible side of a PECI host controller. A CPU reaches it over a simple 32-bit register bus. Through it, software sets up the engine clocking and sampling, the target address and the transfer lengths. It also loads up to 32 outgoing bytes and launches a transaction. When the transaction ends, software reads back up to 32 returned bytes. The block does not drive the PECI wire itself. A bus engine outside it gets a one-cycle start pulse and the transfer parameters. The engine fetches outgoing bytes through a byte-index port, writes returned bytes into the read store and reports the end of the transfer with a done pulse and four error flags.

Completion and error causes are collected in a status register that software clears by writing ones. A single interrupt line is raised while any status cause with its enable set is pending. Each data direction is split into two 16-byte halves at separate address windows. Every transfer ends with the completion cause set, whether or not errors came with it.

Top module: `peci_host_regs`

## Requirements
- R1: After reset the control register (offset 0x00) reads 0x00080000, which is a sampling point of 8 with everything else clear. The command, length, interrupt-enable and status registers read 0, and `irq` is low.
- R2: Control register fields are: bit 0 clock enable, bit 4 controller enable, bits 10:8 divider exponent, bits 19:16 sampling point. They drive `eng_clk_en`, `eng_en`, `eng_div_exp` and `eng_sample`. Every other bit reads 0.
- R3: The length register at 0x0C holds the target in bits 7:0, the write byte count in bits 15:8 and the read byte count in bits 23:16, and bits 31:24 read 0. `eng_tgt` shows the target. `eng_wlen` and `eng_rlen` show each count, with any count above 32 presented as 32.
- R4: Outgoing bytes 0–15 are stored at 0x20–0x2C and bytes 16–31 at 0x40–0x4C. Each word is little-endian, with the lowest byte index in bits 7:0. The words read back as written, and `eng_wr_byte` returns the byte selected by `eng_wr_idx`.
- R5: Writing a 1 in bit 0 of the command register (0x08) while idle sets that bit and raises `eng_start` for exactly the next cycle. Command bits 27:24 then read 1 during the start cycle, 2 while waiting for the engine, and 0 once idle.
- R6: A fire write made while a transfer is active produces no further start pulse. Writing 0 to the command register clears bit 0 but leaves the transfer running.
- R7: An `eng_done` pulse during a transfer sets status bit 0 together with the error flags. `eng_err[0]` sets bit 1 (write-check abort), `eng_err[1]` sets bit 2 (write-check bad), `eng_err[2]` sets bit 3 (bus contention) and `eng_err[3]` sets bit 4 (bus timeout). A done pulse while idle has no effect.
- R8: Status bits 4:0 at 0x1C are cleared only by writing 1 to them. Bits written as 0 keep their value.
- R9: `irq` is high exactly when some status bit is set whose enable bit (0x18, bits 4:0) is also set.
- R10: A byte written by the engine with `eng_rd_we` lands at its index. Read bytes 0–15 appear at 0x30–0x3C and bytes 16–31 at 0x50–0x5C, little-endian. Bus writes to these words have no effect.
- R11: Reads of unmapped or misaligned offsets return 0.
- R12: Bits 31:30 of 0x18 select the timing-negotiation mode (0 first address bit, 1 second address bit, 2 message), read back and drive `eng_nego_sel`. Bits 29:5 read 0.
- R13: Command register bit 31 reflects `eng_pin_mon`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Interrupt request |
| eng_clk_en | output | 1 | Engine clock enable |
| eng_en | output | 1 | Engine enable |
| eng_div_exp | output | 3 | Clock divider exponent |
| eng_sample | output | 4 | Read sampling point |
| eng_nego_sel | output | 2 | Timing-negotiation mode |
| eng_start | output | 1 | One-cycle transfer launch |
| eng_tgt | output | 8 | Target address |
| eng_wlen | output | 8 | Write byte count, limited to 32 |
| eng_rlen | output | 8 | Read byte count, limited to 32 |
| eng_wr_idx | input | 5 | Outgoing byte index requested by the engine |
| eng_wr_byte | output | 8 | Outgoing byte at `eng_wr_idx` |
| eng_rd_we | input | 1 | Returned byte write strobe |
| eng_rd_idx | input | 5 | Returned byte index |
| eng_rd_byte | input | 8 | Returned byte value |
| eng_done | input | 1 | Transfer-finished pulse |
| eng_err | input | 4 | Error flags valid with `eng_done` |
| eng_pin_mon | input | 1 | Bus pin activity flag |

## Verification
The assertions assume that the engine pulses `eng_done` for a single cycle and only after it has seen `eng_start`. They also assume that returned bytes arrive before that done pulse, and that software does not write the status register in the cycle a done pulse lands. The directed stimulus keeps to this. The engine model in the bench raises done only while a transfer is waiting, always after its byte writes. Every bus access there is a separate two-cycle task, so a status clear never coincides with a completion. The one deliberate exception is a done pulse delivered while idle, which is used to show that it is ignored.

// File: rtl/peci_hr_pkg.sv
package peci_hr_pkg;

    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;
    localparam int LEN_W     = 8;
    localparam int NCAUSE    = 5;
    localparam int NERR      = NCAUSE - 1;
    localparam int BUF_BYTES = 32;
    localparam int BUF_WORDS = BUF_BYTES / 4;
    localparam int BIDX_W    = $clog2(BUF_BYTES);
    localparam int WIDX_W    = $clog2(BUF_WORDS);
    localparam int STATE_W   = 4;

    localparam logic [3:0] SAMPLE_RST = 4'd8;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CMD  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_LEN  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_ISTS = 8'h1C;

    typedef enum logic [STATE_W-1:0] {
        SQ_IDLE   = 4'd0,
        SQ_LAUNCH = 4'd1,
        SQ_WAIT   = 4'd2
    } seq_state_e;

    typedef enum logic [2:0] {
        RS_NONE, RS_CTRL, RS_CMD, RS_LEN, RS_IEN, RS_ISTS, RS_WBUF, RS_RBUF
    } reg_sel_e;

    typedef struct packed {
        logic [3:0] sample;
        logic [2:0] div_exp;
        logic       dev_en;
        logic       clk_en;
    } ctrl_t;

    function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
        reg_sel_e r;
        r = RS_NONE;
        if (a[1:0] == 2'b00) begin
            case (a)
                OFS_CTRL: r = RS_CTRL;
                OFS_CMD:  r = RS_CMD;
                OFS_LEN:  r = RS_LEN;
                OFS_IEN:  r = RS_IEN;
                OFS_ISTS: r = RS_ISTS;
                default: begin
                    case (a[7:4])
                        4'h2, 4'h4: r = RS_WBUF;
                        4'h3, 4'h5: r = RS_RBUF;
                        default:    r = RS_NONE;
                    endcase
                end
            endcase
        end
        return r;
    endfunction

    // Buffer word index: the upper half lives in the 0x4x/0x5x window.
    function automatic logic [WIDX_W-1:0] word_index(input logic [ADDR_W-1:0] a);
        return {a[6], a[3:2]};
    endfunction

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] l);
        return (int'(l) > BUF_BYTES) ? LEN_W'(BUF_BYTES) : l;
    endfunction

endpackage

// File: rtl/peci_hr_cfg.sv
module peci_hr_cfg
    import peci_hr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_e          wsel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              set_vld,
    input  logic [NCAUSE-1:0] set_causes,
    output ctrl_t             ctrl,
    output logic [23:0]       len_q,
    output logic [NCAUSE-1:0] ien,
    output logic [1:0]        nego_sel,
    output logic [NCAUSE-1:0] sts,
    output logic              irq
);

    logic [NCAUSE-1:0] clr_mask;
    logic [NCAUSE-1:0] set_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl        <= '0;
            ctrl.sample <= SAMPLE_RST;
            len_q       <= '0;
            ien         <= '0;
            nego_sel    <= '0;
        end else if (wr_en) begin
            case (wsel)
                RS_CTRL: begin
                    ctrl.clk_en  <= wdata[0];
                    ctrl.dev_en  <= wdata[4];
                    ctrl.div_exp <= wdata[10:8];
                    ctrl.sample  <= wdata[19:16];
                end
                RS_LEN: len_q <= wdata[23:0];
                RS_IEN: begin
                    ien      <= wdata[NCAUSE-1:0];
                    nego_sel <= wdata[31:30];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        clr_mask = (wr_en && wsel == RS_ISTS) ? wdata[NCAUSE-1:0] : '0;
        set_mask = set_vld ? set_causes : '0;
    end

    // New causes take priority over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (rst) sts <= '0;
        else     sts <= (sts & ~clr_mask) | set_mask;
    end

    assign irq = |(sts & ien);

    // R8
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wsel == RS_ISTS && !set_vld) |=> ((sts & $past(wdata[NCAUSE-1:0])) == '0));

    // R8
    w1c_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!(wr_en && wsel == RS_ISTS)) |=> ((sts & $past(sts)) == $past(sts)));

endmodule

// File: rtl/peci_hr_buf.sv
module peci_hr_buf
    import peci_hr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wbuf_we,
    input  logic [WIDX_W-1:0] bus_widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [WIDX_W-1:0] bus_ridx,
    output logic [DATA_W-1:0] wbuf_word,
    output logic [DATA_W-1:0] rbuf_word,
    input  logic [BIDX_W-1:0] eng_wr_idx,
    output logic [7:0]        eng_wr_byte,
    input  logic              eng_rd_we,
    input  logic [BIDX_W-1:0] eng_rd_idx,
    input  logic [7:0]        eng_rd_byte
);

    logic [DATA_W-1:0] wmem   [BUF_WORDS];
    logic [7:0]        rbytes [BUF_BYTES];
    logic [DATA_W-1:0] rwords [BUF_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < BUF_WORDS; i++) wmem[i] <= '0;
        end else if (wbuf_we) begin
            wmem[bus_widx] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < BUF_BYTES; i++) rbytes[i] <= '0;
        end else if (eng_rd_we) begin
            rbytes[eng_rd_idx] <= eng_rd_byte;
        end
    end

    for (genvar w = 0; w < BUF_WORDS; w++) begin : g_rword
        for (genvar b = 0; b < 4; b++) begin : g_rbyte
            assign rwords[w][8*b +: 8] = rbytes[4*w + b];
        end
    end

    assign wbuf_word   = wmem[bus_widx];
    assign rbuf_word   = rwords[bus_ridx];
    assign eng_wr_byte = wmem[eng_wr_idx[BIDX_W-1:2]][8*eng_wr_idx[1:0] +: 8];

    // R10
    rd_byte_store_chk: assert property (@(posedge clk) disable iff (rst)
        eng_rd_we |=> (rbytes[$past(eng_rd_idx)] == $past(eng_rd_byte)));

endmodule

// File: rtl/peci_hr_seq.sv
module peci_hr_seq
    import peci_hr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic              cmd_fire,
    input  logic              eng_done,
    input  logic [NERR-1:0]   eng_err,
    output seq_state_e        state,
    output logic              fire_q,
    output logic              eng_start,
    output logic              done_vld,
    output logic [NCAUSE-1:0] done_causes
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
        end else begin
            case (state)
                SQ_IDLE:   if (cmd_wr && cmd_fire) state <= SQ_LAUNCH;
                SQ_LAUNCH: state <= SQ_WAIT;
                SQ_WAIT:   if (eng_done) state <= SQ_IDLE;
                default:   state <= SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fire_q <= 1'b0;
        end else if (cmd_wr) begin
            if (!cmd_fire)              fire_q <= 1'b0;
            else if (state == SQ_IDLE)  fire_q <= 1'b1;
        end
    end

    assign eng_start   = (state == SQ_LAUNCH);
    assign done_vld    = (state == SQ_WAIT) && eng_done;
    assign done_causes = {eng_err, 1'b1};

    // R5
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);

    // R6
    busy_fire_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd_fire && state != SQ_IDLE) |=> !eng_start);

    // R6
    zero_write_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !cmd_fire && state == SQ_WAIT && !eng_done) |=> (state == SQ_WAIT));

endmodule

// File: rtl/peci_host_regs.sv
module peci_host_regs
    import peci_hr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        eng_clk_en,
    output logic        eng_en,
    output logic [2:0]  eng_div_exp,
    output logic [3:0]  eng_sample,
    output logic [1:0]  eng_nego_sel,
    output logic        eng_start,
    output logic [7:0]  eng_tgt,
    output logic [7:0]  eng_wlen,
    output logic [7:0]  eng_rlen,
    input  logic [4:0]  eng_wr_idx,
    output logic [7:0]  eng_wr_byte,
    input  logic        eng_rd_we,
    input  logic [4:0]  eng_rd_idx,
    input  logic [7:0]  eng_rd_byte,
    input  logic        eng_done,
    input  logic [3:0]  eng_err,
    input  logic        eng_pin_mon
);

    reg_sel_e          sel;
    logic              wr_en;
    ctrl_t             ctrl;
    logic [23:0]       len_q;
    logic [NCAUSE-1:0] ien;
    logic [1:0]        nego_sel;
    logic [NCAUSE-1:0] sts;
    seq_state_e        state;
    logic              fire_q;
    logic              done_vld;
    logic [NCAUSE-1:0] done_causes;
    logic [DATA_W-1:0] wbuf_word;
    logic [DATA_W-1:0] rbuf_word;
    logic [WIDX_W-1:0] widx;

    assign sel   = decode(bus_addr);
    assign wr_en = bus_sel && bus_we;
    assign widx  = word_index(bus_addr);

    peci_hr_cfg u_cfg (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wsel       (sel),
        .wdata      (bus_wdata),
        .set_vld    (done_vld),
        .set_causes (done_causes),
        .ctrl       (ctrl),
        .len_q      (len_q),
        .ien        (ien),
        .nego_sel   (nego_sel),
        .sts        (sts),
        .irq        (irq)
    );

    peci_hr_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .cmd_wr      (wr_en && sel == RS_CMD),
        .cmd_fire    (bus_wdata[0]),
        .eng_done    (eng_done),
        .eng_err     (eng_err),
        .state       (state),
        .fire_q      (fire_q),
        .eng_start   (eng_start),
        .done_vld    (done_vld),
        .done_causes (done_causes)
    );

    peci_hr_buf u_buf (
        .clk         (clk),
        .rst         (rst),
        .wbuf_we     (wr_en && sel == RS_WBUF),
        .bus_widx    (widx),
        .wdata       (bus_wdata),
        .bus_ridx    (widx),
        .wbuf_word   (wbuf_word),
        .rbuf_word   (rbuf_word),
        .eng_wr_idx  (eng_wr_idx),
        .eng_wr_byte (eng_wr_byte),
        .eng_rd_we   (eng_rd_we),
        .eng_rd_idx  (eng_rd_idx),
        .eng_rd_byte (eng_rd_byte)
    );

    always_comb begin
        case (sel)
            RS_CTRL: bus_rdata = {12'b0, ctrl.sample, 5'b0, ctrl.div_exp,
                                  3'b0, ctrl.dev_en, 3'b0, ctrl.clk_en};
            RS_CMD:  bus_rdata = {eng_pin_mon, 3'b0, state, 23'b0, fire_q};
            RS_LEN:  bus_rdata = {8'b0, len_q};
            RS_IEN:  bus_rdata = {nego_sel, 25'b0, ien};
            RS_ISTS: bus_rdata = {27'b0, sts};
            RS_WBUF: bus_rdata = wbuf_word;
            RS_RBUF: bus_rdata = rbuf_word;
            default: bus_rdata = '0;
        endcase
    end

    assign eng_clk_en   = ctrl.clk_en;
    assign eng_en       = ctrl.dev_en;
    assign eng_div_exp  = ctrl.div_exp;
    assign eng_sample   = ctrl.sample;
    assign eng_nego_sel = nego_sel;
    assign eng_tgt      = len_q[7:0];
    assign eng_wlen     = clamp_len(len_q[15:8]);
    assign eng_rlen     = clamp_len(len_q[23:16]);

    // R7
    done_sets_status_chk: assert property (@(posedge clk) disable iff (rst)
        done_vld |=> (sts[0] && ((sts[NCAUSE-1:1] & $past(eng_err)) == $past(eng_err))));

    // R3
    len_limit_chk: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> (int'(eng_wlen) <= BUF_BYTES && int'(eng_rlen) <= BUF_BYTES));

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ((sts & ien) != '0));

endmodule

// File: tb/sim_peci_host_regs.sv
module sim_peci_host_regs;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        eng_clk_en, eng_en, eng_start;
    logic [2:0]  eng_div_exp;
    logic [3:0]  eng_sample;
    logic [1:0]  eng_nego_sel;
    logic [7:0]  eng_tgt, eng_wlen, eng_rlen, eng_wr_byte;
    logic [4:0]  eng_wr_idx = '0;
    logic        eng_rd_we = 1'b0;
    logic [4:0]  eng_rd_idx = '0;
    logic [7:0]  eng_rd_byte = '0;
    logic        eng_done = 1'b0;
    logic [3:0]  eng_err = '0;
    logic        eng_pin_mon = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    peci_host_regs u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .eng_clk_en(eng_clk_en), .eng_en(eng_en),
        .eng_div_exp(eng_div_exp), .eng_sample(eng_sample),
        .eng_nego_sel(eng_nego_sel), .eng_start(eng_start),
        .eng_tgt(eng_tgt), .eng_wlen(eng_wlen), .eng_rlen(eng_rlen),
        .eng_wr_idx(eng_wr_idx), .eng_wr_byte(eng_wr_byte),
        .eng_rd_we(eng_rd_we), .eng_rd_idx(eng_rd_idx), .eng_rd_byte(eng_rd_byte),
        .eng_done(eng_done), .eng_err(eng_err), .eng_pin_mon(eng_pin_mon)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    task automatic eng_put(input logic [4:0] idx, input logic [7:0] b);
        @(negedge clk);
        eng_rd_we = 1'b1; eng_rd_idx = idx; eng_rd_byte = b;
        @(negedge clk);
        eng_rd_we = 1'b0;
    endtask

    task automatic eng_finish(input logic [3:0] e);
        @(negedge clk);
        eng_done = 1'b1; eng_err = e;
        @(negedge clk);
        eng_done = 1'b0; eng_err = '0;
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    endtask

    task automatic t_reset();
        rd_chk("R1", 8'h00, 32'h0008_0000);
        rd_chk("R1", 8'h08, 32'h0);
        rd_chk("R1", 8'h0C, 32'h0);
        rd_chk("R1", 8'h18, 32'h0);
        rd_chk("R1", 8'h1C, 32'h0);
        chk("R1", {31'b0, irq}, 32'h0);
        chk("R1", {28'b0, eng_sample}, 32'd8);
    endtask

    task automatic t_ctrl();
        wr(8'h00, 32'hFFFF_FFFF);
        rd_chk("R2", 8'h00, 32'h000F_0711);
        chk("R2", {29'b0, eng_div_exp}, 32'd7);
        chk("R2", {30'b0, eng_clk_en, eng_en}, 32'h3);
        wr(8'h00, 32'h0003_0510);
        rd_chk("R2", 8'h00, 32'h0003_0510);
        chk("R2", {28'b0, eng_sample}, 32'd3);
        chk("R2", {30'b0, eng_clk_en, eng_en}, 32'h1);
        wr(8'h00, 32'h0008_0011);
    endtask

    task automatic t_nego();
        wr(8'h18, 32'h8000_0000);
        rd_chk("R12", 8'h18, 32'h8000_0000);
        chk("R12", {30'b0, eng_nego_sel}, 32'd2);
        wr(8'h18, 32'hFFFF_FFFF);
        rd_chk("R12", 8'h18, 32'hC000_001F);
        wr(8'h18, 32'h0);
    endtask

    task automatic t_len();
        wr(8'h0C, 32'hFF2A_2153);
        rd_chk("R3", 8'h0C, 32'h002A_2153);
        chk("R3", {24'b0, eng_tgt}, 32'h53);
        chk("R3", {24'b0, eng_wlen}, 32'd32);
        chk("R3", {24'b0, eng_rlen}, 32'd32);
        wr(8'h0C, 32'h0020_1030);
        chk("R3", {eng_rlen, eng_wlen, eng_tgt}, 32'h0020_1030);
    endtask

    task automatic t_wbuf();
        wr(8'h20, 32'h4433_2211);
        wr(8'h2C, 32'h8877_6655);
        wr(8'h40, 32'hAABB_CCDD);
        wr(8'h4C, 32'h0102_0304);
        rd_chk("R4", 8'h40, 32'hAABB_CCDD);
        rd_chk("R4", 8'h2C, 32'h8877_6655);
        @(negedge clk); eng_wr_idx = 5'd0;  #1 chk("R4", {24'b0, eng_wr_byte}, 32'h11);
        @(negedge clk); eng_wr_idx = 5'd3;  #1 chk("R4", {24'b0, eng_wr_byte}, 32'h44);
        @(negedge clk); eng_wr_idx = 5'd12; #1 chk("R4", {24'b0, eng_wr_byte}, 32'h55);
        @(negedge clk); eng_wr_idx = 5'd16; #1 chk("R4", {24'b0, eng_wr_byte}, 32'hDD);
        @(negedge clk); eng_wr_idx = 5'd31; #1 chk("R4", {24'b0, eng_wr_byte}, 32'h01);
    endtask

    task automatic t_xfer();
        wr(8'h08, 32'h1);
        chk("R5", {31'b0, eng_start}, 32'h1);
        rd_chk("R5", 8'h08, 32'h0200_0001);
        chk("R5", {31'b0, eng_start}, 32'h0);
        eng_put(5'd0, 8'hA0);
        eng_put(5'd1, 8'hA1);
        eng_put(5'd2, 8'hA2);
        eng_put(5'd3, 8'hA3);
        eng_put(5'd16, 8'h5E);
        eng_put(5'd31, 8'h7F);
        eng_finish(4'b0000);
        rd_chk("R7", 8'h1C, 32'h1);
        rd_chk("R5", 8'h08, 32'h0000_0001);
        rd_chk("R10", 8'h30, 32'hA3A2_A1A0);
        rd_chk("R10", 8'h50, 32'h0000_005E);
        rd_chk("R10", 8'h5C, 32'h7F00_0000);
        wr(8'h08, 32'h0);
        wr(8'h1C, 32'h1);
        rd_chk("R8", 8'h1C, 32'h0);
    endtask

    task automatic t_busy();
        wr(8'h08, 32'h1);
        chk("R5", {31'b0, eng_start}, 32'h1);
        wr(8'h08, 32'h1);
        chk("R6", {31'b0, eng_start}, 32'h0);
        @(negedge clk);
        chk("R6", {31'b0, eng_start}, 32'h0);
        wr(8'h08, 32'h0);
        rd_chk("R6", 8'h08, 32'h0200_0000);
        eng_finish(4'b0000);
        rd_chk("R6", 8'h08, 32'h0);
        rd_chk("R7", 8'h1C, 32'h1);
        wr(8'h1C, 32'h1F);
    endtask

    task automatic t_err_irq();
        wr(8'h08, 32'h1);
        eng_finish(4'b1010);
        wr(8'h08, 32'h0);
        rd_chk("R7", 8'h1C, 32'h15);
        chk("R9", {31'b0, irq}, 32'h0);
        wr(8'h18, 32'h08);
        chk("R9", {31'b0, irq}, 32'h0);
        wr(8'h18, 32'h10);
        chk("R9", {31'b0, irq}, 32'h1);
        wr(8'h1C, 32'h04);
        rd_chk("R8", 8'h1C, 32'h11);
        chk("R9", {31'b0, irq}, 32'h1);
        wr(8'h1C, 32'h10);
        rd_chk("R8", 8'h1C, 32'h01);
        chk("R9", {31'b0, irq}, 32'h0);
        wr(8'h18, 32'h01);
        chk("R9", {31'b0, irq}, 32'h1);
        wr(8'h1C, 32'h1F);
        chk("R9", {31'b0, irq}, 32'h0);
        wr(8'h18, 32'h0);
    endtask

    task automatic t_idle_done();
        eng_finish(4'b1111);
        rd_chk("R7", 8'h1C, 32'h0);
        rd_chk("R7", 8'h08, 32'h0);
    endtask

    task automatic t_ignored();
        wr(8'h30, 32'hFFFF_FFFF);
        rd_chk("R10", 8'h30, 32'hA3A2_A1A0);
        rd_chk("R11", 8'h10, 32'h0);
        rd_chk("R11", 8'h60, 32'h0);
        rd_chk("R11", 8'h04, 32'h0);
        rd_chk("R11", 8'h22, 32'h0);
    endtask

    task automatic t_pinmon();
        @(negedge clk); eng_pin_mon = 1'b1;
        rd_chk("R13", 8'h08, 32'h8000_0000);
        @(negedge clk); eng_pin_mon = 1'b0;
        rd_chk("R13", 8'h08, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ctrl();
        t_nego();
        t_len();
        t_wbuf();
        t_xfer();
        t_busy();
        t_err_irq();
        t_idle_done();
        t_ignored();
        t_pinmon();
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

endmodule